// File: doc/BRIEF.md
# Greedy Flip Search Controller for Boolean Satisfiability

This controller runs a greedy local search for a satisfying assignment of a clause formula. The formula itself lives outside, in a clause tracking array. The controller presents a candidate assignment to that array, and the array answers in the same cycle with the number of clauses the candidate satisfies. After a start request the controller first builds a random starting assignment, one bit per cycle, from an external random bit source. It then measures how many clauses that assignment satisfies.

The controller then works in steps. In each step it walks every variable once, one per cycle, and asks the array how many clauses would be satisfied if that one variable were inverted. It keeps the candidate with the largest gain over the current count. When a later candidate has the same gain as the best so far, the random bit decides whether the later one replaces it. At the end of the walk the best candidate is flipped for good, even when its gain is zero or negative, and the stored count moves by that gain. A step whose best gain is not positive counts as one used attempt.

The search stops in one of two ways. It stops with success as soon as the stored count equals the clause count. It stops with failure once the used attempts reach the budget. Either way the controller pulses `done` and presents the final assignment.

Top module: `gsat_search_ctrl`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `busy`, `done` and `success` are 0 and `result` is all zeros. A reset in the middle of a search abandons that search.
- R2: `start` is taken only while `busy` is 0. In the cycle after it is taken, `busy` is 1 and `success` is 0. A `start` raised while `busy` is 1 has no effect on the run's timing or outcome.
- R3: The starting assignment is gathered over NV cycles right after `start` is taken. The k-th bit sampled on `rnd_bit` (k counted from 0) becomes variable k. In the cycle after the last bit is gathered, `trk_asg` shows that assignment and `trk_eval` is 1.
- R4: In each search step, `trk_asg` shows the current assignment with exactly one bit inverted, bit k in the k-th cycle of the walk, for k = 0 to NV-1. `trk_eval` is 1 in every walk cycle.
- R5: The gain of a candidate is its satisfied count minus the current count. A candidate with a strictly larger gain always becomes the best. A candidate whose gain equals the best so far replaces it only when `rnd_bit` is 1 in that walk cycle.
- R6: After each walk the best candidate's variable is inverted in the stored assignment and the stored count moves by its gain. This happens even when the gain is zero or negative.
- R7: The attempt count rises by one only after a walk whose best gain is zero or negative. The search ends with `success` = 0 when the count reaches MAX_ATT.
- R8: The search ends with `success` = 1 when the stored count equals NC. This test is made after the starting count and after every flip, and it takes priority over the attempt limit.
- R9: `done` is a single-cycle pulse. If the starting assignment already satisfies every clause, `done` goes high NV+2 cycles after the clock edge that takes `start`. Each flip step adds NV+2 cycles to that.
- R10: `result` carries the final stored assignment on both outcomes. `result` and `success` keep their values until the next `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new search; taken only when idle |
| rnd_bit | input | 1 | Random bit, sampled every cycle for the start assignment and for tie breaking |
| trk_asg | output | NV | Candidate assignment presented to the tracking array |
| trk_sat | input | $clog2(NC+1) | Satisfied clause count for `trk_asg`, valid in the same cycle |
| trk_eval | output | 1 | High in the cycles where `trk_sat` is sampled |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a search ends |
| success | output | 1 | Last search found a satisfying assignment |
| result | output | NV | Final assignment of the last search |

## Verification
Most internal faults change the number of flip steps, so they first show up at the ports as a `done` pulse arriving a multiple of NV+2 cycles early or late. A wrong candidate choice, a tie resolved the wrong way, or a flip of the wrong bit instead leaves the final `result` different from the hand-derived value, visible in the cycle `done` pulses. A fault in the walk or in the gathering of the start assignment appears on `trk_asg` at once, in the first walk after `start`. Attempt counting errors show up either as a failure reported on a formula that needs several improving flips, or as a wrong end time on a formula that cannot be satisfied.

// File: rtl/gsat_search_ctrl.sv
module gsat_search_ctrl #(
  parameter int NV      = 8,
  parameter int NC      = 16,
  parameter int MAX_ATT = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      rnd_bit,
  output logic [NV-1:0]             trk_asg,
  input  logic [$clog2(NC+1)-1:0]   trk_sat,
  output logic                      trk_eval,
  output logic                      busy,
  output logic                      done,
  output logic                      success,
  output logic [NV-1:0]             result
);

  localparam int IW = (NV > 1) ? $clog2(NV) : 1;
  localparam int CW = $clog2(NC+1);
  localparam int GW = CW + 1;
  localparam int AW = $clog2(MAX_ATT+1);
  localparam logic signed [GW-1:0] GAIN_MIN = {1'b1, {(GW-1){1'b0}}};

  typedef enum logic [2:0] {S_IDLE, S_RAND, S_INIT, S_CHECK, S_SCAN, S_PICK} state_t;

  state_t                 state;
  logic [NV-1:0]          base;
  logic [IW-1:0]          idx, best_idx;
  logic [CW-1:0]          base_cnt;
  logic signed [GW-1:0]   best, gain;
  logic [AW-1:0]          att;
  logic                   take, last, solved, spent;

  assign gain     = $signed({1'b0, trk_sat}) - $signed({1'b0, base_cnt});
  assign take     = (gain > best) || ((gain == best) && rnd_bit);
  assign last     = (idx == IW'(NV-1));
  assign solved   = (base_cnt == CW'(NC));
  assign spent    = (att == AW'(MAX_ATT));
  assign busy     = (state != S_IDLE);
  assign trk_eval = (state == S_INIT) || (state == S_SCAN);
  assign trk_asg  = (state == S_SCAN) ? (base ^ (NV'(1) << idx)) : base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      base     <= '0;
      idx      <= '0;
      best_idx <= '0;
      base_cnt <= '0;
      best     <= GAIN_MIN;
      att      <= '0;
      done     <= 1'b0;
      success  <= 1'b0;
      result   <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_RAND;
            idx     <= '0;
            att     <= '0;
            success <= 1'b0;
          end
        end
        S_RAND: begin
          base <= {rnd_bit, base[NV-1:1]};
          idx  <= idx + IW'(1);
          if (last) state <= S_INIT;
        end
        S_INIT: begin
          base_cnt <= trk_sat;
          state    <= S_CHECK;
        end
        S_CHECK: begin
          if (solved || spent) begin
            done    <= 1'b1;
            success <= solved;
            result  <= base;
            state   <= S_IDLE;
          end else begin
            idx   <= '0;
            best  <= GAIN_MIN;
            state <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (take) begin
            best     <= gain;
            best_idx <= idx;
          end
          idx <= idx + IW'(1);
          if (last) state <= S_PICK;
        end
        S_PICK: begin
          base     <= base ^ (NV'(1) << best_idx);
          base_cnt <= base_cnt + CW'(best);
          if (best <= 0) att <= att + AW'(1);
          state <= S_CHECK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && !success));

  assert_walk_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SCAN && !last) |=> (state == S_SCAN && idx == $past(idx) + IW'(1)));

  assert_eval_in_search_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trk_eval |-> busy);

  assert_attempt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    att <= AW'(MAX_ATT));

  assert_success_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && success) |-> (base_cnt == CW'(NC)));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && result == base));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(success) && $stable(result)));

endmodule

// File: tb/gsat_search_ctrl_bench.sv
module gsat_search_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV   = 4;
  localparam int NC   = 4;
  localparam int MATT = 3;

  typedef struct packed {
    logic [15:0] pos;
    logic [15:0] neg;
    logic [3:0]  init;
    logic        tie;
    logic        succ;
    logic [3:0]  res;
    logic [7:0]  cyc;
  } vec_t;

  // clause c uses bits [4c+3:4c]; bit i of a mask means literal xi (pos) or ~xi (neg)
  localparam vec_t VECS [7] = '{
    '{16'h8421, 16'h0000, 4'hF, 1'b0, 1'b1, 4'hF, 8'd6},   // R9 R8 already satisfied
    '{16'h8421, 16'h0000, 4'hE, 1'b0, 1'b1, 4'hF, 8'd12},  // R6 one improving flip
    '{16'hC843, 16'h0000, 4'hC, 1'b0, 1'b1, 4'hD, 8'd12},  // R5 tie kept on rnd 0
    '{16'hC843, 16'h0000, 4'hC, 1'b1, 1'b1, 4'hE, 8'd12},  // R5 tie replaced on rnd 1
    '{16'h0201, 16'h2010, 4'h0, 1'b0, 1'b0, 4'h1, 8'd24},  // R7 unsatisfiable, budget spent
    '{16'h0201, 16'h2010, 4'h0, 1'b1, 1'b0, 4'h8, 8'd24},  // R7 R5 unsatisfiable, last tie wins
    '{16'h8421, 16'h0000, 4'h0, 1'b0, 1'b1, 4'hF, 8'd30}   // R7 positive flips not counted
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rnd_bit = 1'b0;
  logic [3:0]  trk_asg;
  logic [2:0]  trk_sat;
  logic        trk_eval, busy, done, success;
  logic [3:0]  result;
  logic [15:0] fpos = '0;
  logic [15:0] fneg = '0;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    trk_sat = '0;
    for (int c = 0; c < NC; c++)
      if (((fpos[c*4 +: 4] & trk_asg) | (fneg[c*4 +: 4] & ~trk_asg)) != 4'h0)
        trk_sat = trk_sat + 3'd1;
  end

  gsat_search_ctrl #(.NV(NV), .NC(NC), .MAX_ATT(MATT)) u_gsat_search_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .rnd_bit(rnd_bit),
    .trk_asg(trk_asg), .trk_sat(trk_sat), .trk_eval(trk_eval),
    .busy(busy), .done(done), .success(success), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic idle_zero(input string req);
    chk(!busy && !done && !success && result == 4'h0, req,
        {busy, done, success, result}, 0);
  endtask

  task automatic run_vec(input vec_t v, input int poke_at);
    int cyc;
    logic [3:0] exp_asg;
    fpos = v.pos;
    fneg = v.neg;
    @(negedge clk);
    start   = 1'b1;
    rnd_bit = v.init[0];
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(success == 1'b0, "R2 success cleared on start", success, 0);
    cyc = 0;
    while (!done && cyc < 400) begin
      rnd_bit = (cyc < NV) ? v.init[cyc] : v.tie;
      start   = (cyc == poke_at);
      @(posedge clk); #1;
      cyc++;
      if (cyc == NV)
        chk(trk_asg == v.init && trk_eval, "R3 start assignment", trk_asg, v.init);
      if (!done && cyc >= NV+2 && cyc < 2*NV+2) begin
        exp_asg = v.init ^ (4'b0001 << (cyc-NV-2));
        chk(trk_asg == exp_asg && trk_eval, "R4 walk candidate", trk_asg, exp_asg);
      end
    end
    start = 1'b0;
    chk(cyc == int'(v.cyc), "R9 done latency", cyc, v.cyc);
    chk(success == v.succ, "R8 R7 outcome", success, v.succ);
    chk(result == v.res, "R5 R6 final assignment", result, v.res);
    @(posedge clk); #1;
    chk(!done, "R9 done is one cycle", done, 0);
    repeat (3) @(posedge clk);
    #1;
    chk(success == v.succ && result == v.res && !busy, "R10 outputs held",
        {success, result}, {v.succ, v.res});
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    idle_zero("R1 outputs in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    idle_zero("R1 outputs after reset");

    for (int i = 0; i < 7; i++) run_vec(VECS[i], -1);

    // R2: start raised mid search is ignored
    run_vec(VECS[6], 10);

    // R1: reset in the middle of a search
    fpos = VECS[6].pos;
    fneg = VECS[6].neg;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    #1;
    idle_zero("R1 reset abandons search");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk(!busy && !done, "R1 stays idle after reset", busy, 0);

    run_vec(VECS[1], -1);
    finish_run();
  end
endmodule